// File: doc/BRIEF.md
# Bus Address Decoder with SRAM Remap

This block performs first-level address decoding for a 32-bit on-chip bus. It is purely combinational from address to selects. The only state is one register that records whether the remap command has arrived. The upper four address bits divide the address space into sixteen regions of 256 MB. Each region is steered to one target:

- the internal-memory region;
- one of six external chip selects;
- the DDR memory chip select;
- the peripheral bridge;
- an abort response for regions that hold nothing.

Inside the internal-memory region, a second decode level recognises the 64 KB on-chip SRAM window at 0x0030_0000. It enables one of four 16 KB SRAM blocks and passes the low address bits through as the block offset. A one-cycle remap pulse sets a sticky flag. After that, the same SRAM also answers at address zero, which lets boot code place vectors in RAM. The flag holds until reset.

Top module: `bus_addr_decoder`

## Requirements
- R1: The region number is addr_in[31:28]. Each of the 16 regions spans 256 MB, and every output except remap_active depends only on that field, the lower address bits, valid_in and remap_active.
- R2: With valid_in high, regions 1 to 6 assert ext_cs[region-1] (ext_cs bit 0 for region 1 through bit 5 for region 6).
- R3: With valid_in high, region 7 asserts ddr_cs.
- R4: With valid_in high, region 15 asserts periph_sel.
- R5: With valid_in high, regions 8 to 14 assert abort and no select.
- R6: With valid_in high, region 0 addresses with addr_in[27:16] equal to 0x030 (0x0030_0000 to 0x0030_FFFF) assert sram_sel, whatever the remap state.
- R7: remap_active is 0 after reset. It becomes 1 in the cycle after a clock edge that samples remap_pulse high, and it then stays 1 until the next reset.
- R8: With valid_in high and remap_active 1, region 0 addresses with addr_in[27:16] equal to 0 assert sram_sel. With remap_active 0, the same addresses assert abort.
- R9: With valid_in high, any other region 0 address asserts abort.
- R10: While sram_sel is 1, sram_blk_en has exactly bit addr_in[15:14] set and sram_offset equals addr_in[13:0]. While sram_sel is 0, both are zero.
- R11: With valid_in low, sram_sel, ext_cs, ddr_cs, periph_sel, abort, sram_blk_en and sram_offset are all zero.
- R12: With valid_in high, exactly one of sram_sel, the six ext_cs bits, ddr_cs, periph_sel and abort is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the remap flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| remap_pulse | input | 1 | One-cycle remap command |
| valid_in | input | 1 | Address is valid this cycle |
| addr_in | input | 32 | Bus address |
| sram_sel | output | 1 | On-chip SRAM selected |
| sram_blk_en | output | 4 | One-hot SRAM block enable |
| sram_offset | output | 14 | Offset inside the selected SRAM block |
| ext_cs | output | 6 | External chip selects |
| ddr_cs | output | 1 | DDR memory chip select |
| periph_sel | output | 1 | Peripheral bridge select |
| abort | output | 1 | Access to unmapped space |
| remap_active | output | 1 | Sticky remap flag |

## Verification
All selects, the abort flag, the block enables and the offset settle in the same cycle as the address and valid_in, with no register in between. The bench therefore drives inputs on the falling edge and compares a quarter period later, before the next rising edge. The remap flag is the only registered result. It is due one rising edge after the pulse is sampled, so the bench reference model updates its own flag on that edge. From that compare onward, the model expects the zero-address alias, and it expects the flag to return to 0 at a reset.

// File: rtl/bad_pkg.sv
package bad_pkg;
  localparam int BANK_W = 4;
  localparam int N_BANK = 1 << BANK_W;

  typedef enum logic [2:0] {
    TGT_INTERNAL,
    TGT_EXT,
    TGT_DDR,
    TGT_PERIPH,
    TGT_UNUSED
  } tgt_e;

  // First-level map: bank 0 internal, 1..n_ext external, next DDR, top bridge
  function automatic tgt_e bank_target(input int unsigned bank,
                                       input int unsigned n_ext);
    tgt_e t;
    if (bank == 0)                      t = TGT_INTERNAL;
    else if (bank <= n_ext)             t = TGT_EXT;
    else if (bank == n_ext + 1)         t = TGT_DDR;
    else if (bank == N_BANK - 1)        t = TGT_PERIPH;
    else                                t = TGT_UNUSED;
    return t;
  endfunction
endpackage

// File: rtl/bad_bank_decoder.sv
module bad_bank_decoder
  import bad_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_EXT  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank_idx,
  output logic              hit_internal,
  output logic [N_EXT-1:0]  hit_ext,
  output logic              hit_ddr,
  output logic              hit_periph,
  output logic              hit_unused
);
  tgt_e tgt;

  assign bank_idx = addr[ADDR_W-1 -: BANK_W];
  assign tgt      = bank_target(int'(bank_idx), N_EXT);

  assign hit_internal = (tgt == TGT_INTERNAL);
  assign hit_ddr      = (tgt == TGT_DDR);
  assign hit_periph   = (tgt == TGT_PERIPH);
  assign hit_unused   = (tgt == TGT_UNUSED);

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign hit_ext[g] = (tgt == TGT_EXT) && (bank_idx == BANK_W'(g + 1));
  end
endmodule

// File: rtl/bad_sram_decoder.sv
module bad_sram_decoder
  import bad_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int N_BLK     = 4,
  parameter int BLK_OFF_W = 14,
  parameter int WIN_TAG   = 'h030
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 remap_active,
  output logic                 in_main_win,
  output logic                 in_alias_win,
  output logic [N_BLK-1:0]     blk_en,
  output logic [BLK_OFF_W-1:0] offset
);
  localparam int BLK_SEL_W = $clog2(N_BLK);
  localparam int WIN_LO    = BLK_OFF_W + BLK_SEL_W;
  localparam int TAG_W     = ADDR_W - BANK_W - WIN_LO;

  logic [TAG_W-1:0]     tag;
  logic [BLK_SEL_W-1:0] blk_idx;

  assign tag     = addr[WIN_LO +: TAG_W];
  assign blk_idx = addr[BLK_OFF_W +: BLK_SEL_W];

  assign in_main_win  = (tag == TAG_W'(WIN_TAG));
  assign in_alias_win = remap_active && (tag == '0);

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    assign blk_en[b] = (blk_idx == BLK_SEL_W'(b));
  end

  assign offset = addr[BLK_OFF_W-1:0];
endmodule

// File: rtl/bad_remap_reg.sv
module bad_remap_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic remap_pulse,
  output logic remap_active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           remap_active <= 1'b0;
    else if (remap_pulse) remap_active <= 1'b1;
  end
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
  import bad_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int N_EXT     = 6,
  parameter int N_BLK     = 4,
  parameter int BLK_OFF_W = 14,
  parameter int WIN_TAG   = 'h030
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 remap_pulse,
  input  logic                 valid_in,
  input  logic [ADDR_W-1:0]    addr_in,
  output logic                 sram_sel,
  output logic [N_BLK-1:0]     sram_blk_en,
  output logic [BLK_OFF_W-1:0] sram_offset,
  output logic [N_EXT-1:0]     ext_cs,
  output logic                 ddr_cs,
  output logic                 periph_sel,
  output logic                 abort,
  output logic                 remap_active
);
  // Named internal events, visible to the bound checker
  logic [BANK_W-1:0]    bank_idx;
  logic                 hit_internal;
  logic [N_EXT-1:0]     hit_ext;
  logic                 hit_ddr;
  logic                 hit_periph;
  logic                 hit_unused;
  logic                 in_main_win;
  logic                 in_alias_win;
  logic                 sram_hit;
  logic                 internal_miss;
  logic [N_BLK-1:0]     blk_en_raw;
  logic [BLK_OFF_W-1:0] offset_raw;

  bad_remap_reg u_remap (
    .clk          (clk),
    .rst_n        (rst_n),
    .remap_pulse  (remap_pulse),
    .remap_active (remap_active)
  );

  bad_bank_decoder #(.ADDR_W(ADDR_W), .N_EXT(N_EXT)) u_bank (
    .addr         (addr_in),
    .bank_idx     (bank_idx),
    .hit_internal (hit_internal),
    .hit_ext      (hit_ext),
    .hit_ddr      (hit_ddr),
    .hit_periph   (hit_periph),
    .hit_unused   (hit_unused)
  );

  bad_sram_decoder #(
    .ADDR_W(ADDR_W), .N_BLK(N_BLK), .BLK_OFF_W(BLK_OFF_W), .WIN_TAG(WIN_TAG)
  ) u_sram (
    .addr         (addr_in),
    .remap_active (remap_active),
    .in_main_win  (in_main_win),
    .in_alias_win (in_alias_win),
    .blk_en       (blk_en_raw),
    .offset       (offset_raw)
  );

  assign sram_hit      = hit_internal && (in_main_win || in_alias_win);
  assign internal_miss = hit_internal && !sram_hit;

  assign sram_sel    = valid_in && sram_hit;
  assign sram_blk_en = sram_sel ? blk_en_raw : '0;
  assign sram_offset = sram_sel ? offset_raw : '0;
  assign ext_cs      = valid_in ? hit_ext : '0;
  assign ddr_cs      = valid_in && hit_ddr;
  assign periph_sel  = valid_in && hit_periph;
  assign abort       = valid_in && (hit_unused || internal_miss);
endmodule

// File: rtl/bad_checker.sv
module bad_checker #(
  parameter int N_EXT     = 6,
  parameter int N_BLK     = 4,
  parameter int BLK_OFF_W = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 remap_pulse,
  input logic                 valid_in,
  input logic [3:0]           bank_idx,
  input logic                 sram_sel,
  input logic [N_BLK-1:0]     sram_blk_en,
  input logic [BLK_OFF_W-1:0] sram_offset,
  input logic [N_EXT-1:0]     ext_cs,
  input logic                 ddr_cs,
  input logic                 periph_sel,
  input logic                 abort,
  input logic                 remap_active
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |-> ($countones({sram_sel, ext_cs, ddr_cs, periph_sel, abort}) == 1)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |-> ({sram_sel, ext_cs, ddr_cs, periph_sel, abort, sram_blk_en, sram_offset} == '0)); // R11
  AST_REMAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    remap_active |=> remap_active); // R7
  AST_REMAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    remap_pulse |=> remap_active); // R7
  AST_BLK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    sram_sel |-> $onehot0(sram_blk_en) && (sram_blk_en != '0)); // R10
  AST_BLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_sel |-> (sram_blk_en == '0)); // R10
  AST_DDR_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_cs |-> (bank_idx == 4'd7)); // R3
  AST_PERIPH_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    periph_sel |-> (bank_idx == 4'd15)); // R4
  AST_UNUSED_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && bank_idx >= 4'd8 && bank_idx <= 4'd14) |-> abort); // R5
endmodule

bind bus_addr_decoder bad_checker #(
  .N_EXT(N_EXT), .N_BLK(N_BLK), .BLK_OFF_W(BLK_OFF_W)
) u_bad_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .remap_pulse  (remap_pulse),
  .valid_in     (valid_in),
  .bank_idx     (bank_idx),
  .sram_sel     (sram_sel),
  .sram_blk_en  (sram_blk_en),
  .sram_offset  (sram_offset),
  .ext_cs       (ext_cs),
  .ddr_cs       (ddr_cs),
  .periph_sel   (periph_sel),
  .abort        (abort),
  .remap_active (remap_active)
);

// File: tb/bus_addr_decoder_bench.sv
module bus_addr_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        remap_pulse = 1'b0;
  logic        valid_in = 1'b0;
  logic [31:0] addr_in = '0;
  logic        sram_sel;
  logic [3:0]  sram_blk_en;
  logic [13:0] sram_offset;
  logic [5:0]  ext_cs;
  logic        ddr_cs, periph_sel, abort, remap_active;

  int checks = 0;
  int failures = 0;
  bit model_remap = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_addr_decoder u_bus_addr_decoder (
    .clk(clk), .rst_n(rst_n), .remap_pulse(remap_pulse), .valid_in(valid_in),
    .addr_in(addr_in), .sram_sel(sram_sel), .sram_blk_en(sram_blk_en),
    .sram_offset(sram_offset), .ext_cs(ext_cs), .ddr_cs(ddr_cs),
    .periph_sel(periph_sel), .abort(abort), .remap_active(remap_active)
  );

  // Reference flag (R7): sampled on rising edges
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)           model_remap <= 1'b0;
    else if (remap_pulse) model_remap <= 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%h valid=%0b actual=%h expected=%h", req, addr_in, valid_in, act, exp);
    end
  endtask

  // Behavioural reference of every output for the current inputs
  task automatic compare();
    int unsigned region = addr_in >> 28;
    int unsigned page   = (addr_in >> 16) & 32'hFFF;
    bit e_sram = 0, e_ddr = 0, e_per = 0, e_abort = 0;
    logic [5:0]  e_ext = '0;
    logic [3:0]  e_blk = '0;
    logic [13:0] e_off = '0;
    string tag;
    if (valid_in) begin
      if (region >= 1 && region <= 6) begin e_ext[region-1] = 1'b1; tag = "R2"; end
      else if (region == 7)  begin e_ddr = 1; tag = "R3"; end
      else if (region == 15) begin e_per = 1; tag = "R4"; end
      else if (region != 0)  begin e_abort = 1; tag = "R5"; end
      else if (page == 'h030) begin e_sram = 1; tag = "R6"; end
      else if (page == 0)     begin e_sram = model_remap; e_abort = !model_remap; tag = "R8"; end
      else                    begin e_abort = 1; tag = "R9"; end
      if (e_sram) begin
        e_blk = 4'b0001 << ((addr_in >> 14) % 4);
        e_off = addr_in % (1 << 14);
      end
    end else tag = "R11";
    check({tag, " R1 target"}, {26'd0, sram_sel, ext_cs, ddr_cs, periph_sel, abort},
          {26'd0, e_sram, e_ext, e_ddr, e_per, e_abort});
    check({tag, " R10 block"}, {14'd0, sram_blk_en, sram_offset}, {14'd0, e_blk, e_off});
    check("R7 flag", {31'd0, remap_active}, {31'd0, model_remap});
    if (valid_in)
      check("R12 one", $countones({sram_sel, ext_cs, ddr_cs, periph_sel, abort}), 32'd1);
  endtask

  task automatic step(input logic [31:0] a, input logic v, input logic p);
    @(negedge clk);
    addr_in = a; valid_in = v; remap_pulse = p;
    #(CLK_PERIOD/4);
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Reset state: flag clear (R7), quiet outputs (R11)
    repeat (2) @(negedge clk);
    #(CLK_PERIOD/4);
    compare();
    rst_n = 1'b1;
    // Every region with a fixed low part (R1..R5)
    for (int r = 0; r < 16; r++) step({r[3:0], 28'h0300004}, 1'b1, 1'b0);
    // SRAM window bounds and blocks (R6, R10)
    step(32'h0030_0000, 1, 0);
    step(32'h0030_4ABC, 1, 0);
    step(32'h0030_8001, 1, 0);
    step(32'h0030_FFFF, 1, 0);
    step(32'h0031_0000, 1, 0);   // R9 just above
    step(32'h002F_FFFF, 1, 0);   // R9 just below
    step(32'h0000_0000, 1, 0);   // R8 no alias yet
    step(32'h0000_C123, 1, 0);
    step(32'h0030_1234, 0, 0);   // R11
    step(32'h7000_0000, 0, 0);   // R11
    // Remap pulse, then alias (R7, R8)
    step(32'h0000_0010, 1, 1);   // flag not yet set in this cycle
    step(32'h0000_0010, 1, 0);
    step(32'h0000_C123, 1, 0);
    step(32'h0000_FFFF, 1, 0);
    step(32'h0001_0000, 1, 0);   // R9 beyond alias
    step(32'h0030_7FFF, 1, 0);   // R6 main window still works
    for (int k = 0; k < 5; k++) step(32'h0000_4000, 1, 0); // R7 sticky
    // Mixed addresses biased toward region 0
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a = $urandom;
      case (k % 4)
        0: a[31:16] = 16'h0030;
        1: a[31:16] = 16'h0000;
        default: ;
      endcase
      step(a, (k % 7) != 3, 1'b0);
    end
    // Reset clears the flag (R7)
    @(negedge clk); rst_n = 1'b0; valid_in = 1'b0; remap_pulse = 1'b0;
    #(CLK_PERIOD/4);
    compare();
    @(negedge clk); rst_n = 1'b1;
    step(32'h0000_0000, 1, 0);   // R8 abort again
    for (int k = 0; k < 200; k++) begin
      logic [31:0] a = $urandom;
      if (k % 2 == 0) a[31:16] = (k % 4 == 0) ? 16'h0000 : 16'h0030;
      step(a, 1'b1, (k == 100));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule